// File: doc/BRIEF.md
# Lamp Ballast Start-Up Sequencer

This block steps a fluorescent lamp ballast through its start-up phases: an off state that waits for supply, a filament pre-heat, an ignition sweep, steady run, and a latched stop. Analog comparators are outside the block. It sees their results as synchronous flags: lamp missing, lamp lit, and half-bridge current above the high threshold. It drives a phase code, a frequency-select word for the external oscillator, the half-bridge enable, and the enables for the current-sense and end-of-life monitors.

One fault-timer cycle sets the pre-heat length. The timer counts a charge interval and then a decay interval. A new cycle of the same length then bounds ignition. A separate ramp counter sets the shortest ignition. While ignition runs, the frequency word steps down from the pre-heat value toward the run value. Each cycle in which the high-current flag is set, the word instead steps up by a programmable amount, which holds down the lamp voltage. All lengths and the step size are runtime inputs. Each of these lengths must be at least 1.

Top module: `ballast_seq`

## Requirements
- R1: While `rst` is high, and after reset, `phase` is 0 (off). `hb_en`, `cs_hi_en`, `cs_lo_en`, `eol_en` and `phase_chg` are 0 and `freq_sel` is 0. In the off phase `freq_sel` equals `cfg_freq_pre`.
- R2: The off phase moves to pre-heat (`phase`=1) only in a cycle where `supply_ok`=1 and `lamp_absent`=0. While `lamp_absent`=1 the block stays off with `hb_en`=0, and no timer cycle starts.
- R3: Pre-heat lasts exactly `cfg_charge_len`+`cfg_decay_len` clocks, then ignition (`phase`=2) begins. In pre-heat `freq_sel` equals `cfg_freq_pre`.
- R4: `freq_sel` equals `cfg_freq_pre` in the first ignition cycle. After that, each ignition cycle without a high-current flag lowers it by 1, and it never goes below `cfg_freq_run`.
- R5: Each ignition cycle with `hb_over_hi`=1 raises `freq_sel` by `cfg_freq_step` in the next cycle. The value saturates at all ones. This takes priority over the downward step.
- R6: Ignition moves to run (`phase`=3) at the first clock where the ramp has counted `cfg_ramp_len` ignition cycles and `lamp_lit`=1. The earliest such move comes `cfg_ramp_len`+1 clocks after ignition starts. This move takes priority over the ignition timeout. In run, `freq_sel` equals `cfg_freq_run`.
- R7: If run has not been reached when a second timer cycle of `cfg_charge_len`+`cfg_decay_len` clocks ends, ignition moves to stop (`phase`=4) and `hb_en` drops to 0.
- R8: Stop is left, to pre-heat, only after a re-lamp cycle: `lamp_absent` is seen high (either on the clock that entered stop, or while in stop) and then low. While `lamp_absent` stays low, stop holds.
- R9: `lamp_absent`=1 in pre-heat, ignition or run moves to stop on the next clock. This takes priority over every other transition.
- R10: `hb_over_hi`=1 in run moves to stop on the next clock.
- R11: `hb_en` is high in pre-heat, ignition and run. `cs_hi_en` is high in ignition and run. `cs_lo_en` and `eol_en` are high only in run.
- R12: `phase_chg` is high for exactly the first cycle of each new phase, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high undervoltage reset |
| supply_ok | input | 1 | Supply good flag |
| lamp_absent | input | 1 | Lamp missing flag (re-lamp comparator) |
| lamp_lit | input | 1 | Lamp ignited flag |
| hb_over_hi | input | 1 | Half-bridge current above high threshold |
| cfg_charge_len | input | TW | Timer charge interval, clocks |
| cfg_decay_len | input | TW | Timer decay interval, clocks |
| cfg_ramp_len | input | RW | Ignition ramp length, clocks |
| cfg_freq_step | input | FW | Upward frequency nudge |
| cfg_freq_pre | input | FW | Pre-heat frequency word |
| cfg_freq_run | input | FW | Run frequency word |
| phase | output | 3 | 0 off, 1 pre-heat, 2 ignition, 3 run, 4 stop |
| freq_sel | output | FW | Frequency-select word |
| hb_en | output | 1 | Half-bridge switching enable |
| cs_hi_en | output | 1 | High current-threshold monitor enable |
| cs_lo_en | output | 1 | Low current-threshold monitor enable |
| eol_en | output | 1 | End-of-life window monitor enable |
| phase_chg | output | 1 | One-clock strobe on each phase change |

## Verification
Three pairs of events can land on the same clock edge, and each pair has a defined winner:
- Ignition timeout and a successful ignition. The bench raises `lamp_lit` exactly on the last cycle of the ignition timer cycle and expects run, not stop.
- Pre-heat expiry and a missing lamp. `lamp_absent` is raised on the final pre-heat cycle, and the bench expects stop, not ignition.
- The high-current nudge and the downward frequency step. The bench holds `hb_over_hi` once the word has reached the run floor and expects the step-up to win until the word saturates.

A behavioural model scores every cycle.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_PRE  = 3'd1,
    PH_IGN  = 3'd2,
    PH_RUN  = 3'd3,
    PH_STOP = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    TM_IDLE   = 2'd0,
    TM_CHARGE = 2'd1,
    TM_DECAY  = 2'd2
  } tmr_t;
endpackage

// File: rtl/fault_timer.sv
// Charge-then-decay interval timer: one cycle lasts charge_len + decay_len clocks.
module fault_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          clear,
  input  logic [TW-1:0] charge_len,
  input  logic [TW-1:0] decay_len,
  output logic          done
);
  import ballast_pkg::*;

  tmr_t          st;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= TM_IDLE;
      cnt <= '0;
    end else if (start) begin
      st  <= TM_CHARGE;
      cnt <= '0;
    end else if (clear) begin
      st  <= TM_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        TM_CHARGE: begin
          if (cnt == charge_len - TW'(1)) begin
            st  <= TM_DECAY;
            cnt <= decay_len - TW'(1);
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        TM_DECAY: begin
          if (cnt == '0) st <= TM_IDLE;
          else           cnt <= cnt - TW'(1);
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign done = (st == TM_DECAY) && (cnt == '0);
endmodule

// File: rtl/ign_ramp.sv
// Ignition ramp: counts ignition cycles from zero and saturates at len.
module ign_ramp #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [RW-1:0] len,
  output logic          full
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (cnt != len) cnt <= cnt + RW'(1);
  end

  assign full = (cnt == len);
endmodule

// File: rtl/freq_ctl.sv
// Frequency-select word: held at pre or run, or slewed during ignition.
module freq_ctl #(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slew,
  input  logic          bump,
  input  logic          hold_run,
  input  logic [FW-1:0] step,
  input  logic [FW-1:0] pre_val,
  input  logic [FW-1:0] run_val,
  output logic [FW-1:0] freq
);
  logic [FW:0]   sum;
  logic [FW-1:0] up_val;
  logic [FW-1:0] down_val;

  always_comb begin
    sum      = {1'b0, freq} + {1'b0, step};
    up_val   = sum[FW] ? {FW{1'b1}} : sum[FW-1:0];
    down_val = (freq > run_val) ? freq - FW'(1) : freq;
  end

  always_ff @(posedge clk) begin
    if (rst)           freq <= '0;
    else if (slew)     freq <= bump ? up_val : down_val;
    else if (hold_run) freq <= run_val;
    else               freq <= pre_val;
  end
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq #(
  parameter int TW = 16,
  parameter int RW = 16,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          lamp_absent,
  input  logic          lamp_lit,
  input  logic          hb_over_hi,
  input  logic [TW-1:0] cfg_charge_len,
  input  logic [TW-1:0] cfg_decay_len,
  input  logic [RW-1:0] cfg_ramp_len,
  input  logic [FW-1:0] cfg_freq_step,
  input  logic [FW-1:0] cfg_freq_pre,
  input  logic [FW-1:0] cfg_freq_run,
  output logic [2:0]    phase,
  output logic [FW-1:0] freq_sel,
  output logic          hb_en,
  output logic          cs_hi_en,
  output logic          cs_lo_en,
  output logic          eol_en,
  output logic          phase_chg
);
  import ballast_pkg::*;

  phase_t state;
  phase_t nstate;
  logic   armed;
  logic   armed_n;
  logic   tmr_done;
  logic   ramp_full;
  logic   timed_n;
  logic   tmr_start;
  logic   tmr_clear;
  logic   in_ign;

  fault_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (tmr_start),
    .clear      (tmr_clear),
    .charge_len (cfg_charge_len),
    .decay_len  (cfg_decay_len),
    .done       (tmr_done)
  );

  ign_ramp #(.RW(RW)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .active (in_ign),
    .len    (cfg_ramp_len),
    .full   (ramp_full)
  );

  freq_ctl #(.FW(FW)) u_freq (
    .clk      (clk),
    .rst      (rst),
    .slew     (in_ign && (nstate == PH_IGN)),
    .bump     (hb_over_hi),
    .hold_run (nstate == PH_RUN),
    .step     (cfg_freq_step),
    .pre_val  (cfg_freq_pre),
    .run_val  (cfg_freq_run),
    .freq     (freq_sel)
  );

  assign in_ign = (state == PH_IGN);

  // Next-phase selection; a missing lamp outranks every other exit.
  always_comb begin
    nstate = state;
    case (state)
      PH_OFF:  if (supply_ok && !lamp_absent) nstate = PH_PRE;
      PH_PRE: begin
        if (lamp_absent)   nstate = PH_STOP;
        else if (tmr_done) nstate = PH_IGN;
      end
      PH_IGN: begin
        if (lamp_absent)                nstate = PH_STOP;
        else if (ramp_full && lamp_lit) nstate = PH_RUN;
        else if (tmr_done)              nstate = PH_STOP;
      end
      PH_RUN:  if (lamp_absent || hb_over_hi) nstate = PH_STOP;
      PH_STOP: if (armed && !lamp_absent) nstate = PH_PRE;
      default: nstate = PH_OFF;
    endcase
  end

  always_comb begin
    timed_n   = (nstate == PH_PRE) || (nstate == PH_IGN);
    tmr_start = timed_n && (nstate != state);
    tmr_clear = !timed_n;
    armed_n   = (nstate == PH_STOP) &&
                (((state == PH_STOP) && armed) || lamp_absent);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_OFF;
      armed     <= 1'b0;
      hb_en     <= 1'b0;
      cs_hi_en  <= 1'b0;
      cs_lo_en  <= 1'b0;
      eol_en    <= 1'b0;
      phase_chg <= 1'b0;
    end else begin
      state     <= nstate;
      armed     <= armed_n;
      hb_en     <= (nstate == PH_PRE) || (nstate == PH_IGN) || (nstate == PH_RUN);
      cs_hi_en  <= (nstate == PH_IGN) || (nstate == PH_RUN);
      cs_lo_en  <= (nstate == PH_RUN);
      eol_en    <= (nstate == PH_RUN);
      phase_chg <= (nstate != state);
    end
  end

  assign phase = state;
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk #(
  parameter int FW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          lamp_absent,
  input logic          hb_over_hi,
  input logic [2:0]    phase,
  input logic [FW-1:0] freq_sel,
  input logic          hb_en,
  input logic          cs_hi_en,
  input logic          cs_lo_en,
  input logic          eol_en,
  input logic          phase_chg
);
  assert_off_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && lamp_absent) |=> (phase == 3'd0));

  assert_ign_descend_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd2 && !hb_over_hi) |=> (phase != 3'd2 || freq_sel <= $past(freq_sel)));

  assert_ign_nudge_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd2 && hb_over_hi) |=> (phase != 3'd2 || freq_sel >= $past(freq_sel)));

  assert_stop_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd4 && lamp_absent) |=> (phase == 3'd4));

  assert_absent_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (lamp_absent && (phase == 3'd1 || phase == 3'd2 || phase == 3'd3)) |=> (phase == 3'd4));

  assert_run_overcurrent_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3 && hb_over_hi) |=> (phase == 3'd4));

  assert_eol_only_run_R11: assert property (@(posedge clk) disable iff (rst)
    (eol_en || cs_lo_en) |-> (phase == 3'd3));

  assert_hi_sense_R11: assert property (@(posedge clk) disable iff (rst)
    cs_hi_en |-> (phase == 3'd2 || phase == 3'd3));

  assert_hb_enable_R11: assert property (@(posedge clk) disable iff (rst)
    hb_en |-> (phase >= 3'd1 && phase <= 3'd3));

  assert_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> phase_chg);

  assert_strobe_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (phase == $past(phase)) |-> !phase_chg);
endmodule

bind ballast_seq ballast_seq_chk #(.FW(FW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lamp_absent (lamp_absent),
  .hb_over_hi  (hb_over_hi),
  .phase       (phase),
  .freq_sel    (freq_sel),
  .hb_en       (hb_en),
  .cs_hi_en    (cs_hi_en),
  .cs_lo_en    (cs_lo_en),
  .eol_en      (eol_en),
  .phase_chg   (phase_chg)
);

// File: tb/test_ballast_seq.sv
`timescale 1ns/1ps
module test_ballast_seq;
  localparam int TW = 16;
  localparam int RW = 16;
  localparam int FW = 12;
  localparam int FMAX = (1 << FW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          supply_ok = 1'b0, lamp_absent = 1'b0, lamp_lit = 1'b0, hb_over_hi = 1'b0;
  logic [TW-1:0] cfg_charge_len = 16'd5, cfg_decay_len = 16'd7;
  logic [RW-1:0] cfg_ramp_len = 16'd6;
  logic [FW-1:0] cfg_freq_step = 12'd20, cfg_freq_pre = 12'd200, cfg_freq_run = 12'd100;
  logic [2:0]    phase;
  logic [FW-1:0] freq_sel;
  logic          hb_en, cs_hi_en, cs_lo_en, eol_en, phase_chg;

  ballast_seq #(.TW(TW), .RW(RW), .FW(FW)) i_ballast_seq (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .lamp_absent(lamp_absent),
    .lamp_lit(lamp_lit), .hb_over_hi(hb_over_hi),
    .cfg_charge_len(cfg_charge_len), .cfg_decay_len(cfg_decay_len),
    .cfg_ramp_len(cfg_ramp_len), .cfg_freq_step(cfg_freq_step),
    .cfg_freq_pre(cfg_freq_pre), .cfg_freq_run(cfg_freq_run),
    .phase(phase), .freq_sel(freq_sel), .hb_en(hb_en), .cs_hi_en(cs_hi_en),
    .cs_lo_en(cs_lo_en), .eol_en(eol_en), .phase_chg(phase_chg)
  );

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mp = 0, mtel = -1, mramp = 0, mfreq = 0;
  bit  marmed = 0, mchg = 0, started = 0;

  always @(posedge clk) begin
    int np;
    int cyc_len;
    bit tdone;
    started = 1;
    if (rst) begin
      mp = 0; mtel = -1; mramp = 0; mfreq = 0; marmed = 0; mchg = 0;
    end else begin
      cyc_len = int'(cfg_charge_len) + int'(cfg_decay_len);
      tdone   = (mtel == cyc_len - 1);
      np = mp;
      if (mp == 0) begin
        if (supply_ok && !lamp_absent) np = 1;
      end else if (mp == 1) begin
        if (lamp_absent) np = 4; else if (tdone) np = 2;
      end else if (mp == 2) begin
        if (lamp_absent) np = 4;
        else if (mramp >= int'(cfg_ramp_len) && lamp_lit) np = 3;
        else if (tdone) np = 4;
      end else if (mp == 3) begin
        if (lamp_absent || hb_over_hi) np = 4;
      end else begin
        if (marmed && !lamp_absent) np = 1;
      end
      // frequency
      if (mp == 2 && np == 2) begin
        if (hb_over_hi) mfreq = (mfreq + int'(cfg_freq_step) > FMAX) ? FMAX : mfreq + int'(cfg_freq_step);
        else if (mfreq > int'(cfg_freq_run)) mfreq = mfreq - 1;
      end else if (np == 3) mfreq = int'(cfg_freq_run);
      else mfreq = int'(cfg_freq_pre);
      // timer elapsed clocks
      if ((np == 1 || np == 2) && np != mp) mtel = 0;
      else if (np == 1 || np == 2) mtel = mtel + 1;
      else mtel = -1;
      // ramp
      if (mp != 2) mramp = 0;
      else if (mramp < int'(cfg_ramp_len)) mramp = mramp + 1;
      marmed = (np == 4) && ((mp == 4 && marmed) || lamp_absent);
      mchg = (np != mp);
      mp = np;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(int'(phase) == mp, "R3 phase vs model", int'(phase), mp);
      chk(int'(freq_sel) == mfreq, "R4 freq_sel vs model", int'(freq_sel), mfreq);
      chk(hb_en == (mp >= 1 && mp <= 3), "R11 hb_en", hb_en, (mp >= 1 && mp <= 3));
      chk(cs_hi_en == (mp == 2 || mp == 3), "R11 cs_hi_en", cs_hi_en, (mp == 2 || mp == 3));
      chk(cs_lo_en == (mp == 3), "R11 cs_lo_en", cs_lo_en, (mp == 3));
      chk(eol_en == (mp == 3), "R11 eol_en", eol_en, (mp == 3));
      chk(phase_chg == mchg, "R12 phase_chg", phase_chg, mchg);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_phase(input int p, input string tag);
    int k = 0;
    while (int'(phase) != p && k < 300) begin
      @(negedge clk);
      k++;
    end
    chk(int'(phase) == p, tag, int'(phase), p);
  endtask

  task automatic count_phase(input int p, output int n);
    n = 0;
    while (int'(phase) == p && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int f0;
    repeat (3) @(negedge clk);
    chk(phase == 3'd0, "R1 reset phase", phase, 0);
    chk(!hb_en && !eol_en && !cs_hi_en && !phase_chg, "R1 reset enables", hb_en, 0);
    chk(freq_sel == 12'd0, "R1 reset freq_sel", freq_sel, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(freq_sel == cfg_freq_pre, "R1 off freq_sel", freq_sel, cfg_freq_pre);

    // R2: no supply, then lamp missing at turn-on
    repeat (8) @(negedge clk);
    chk(phase == 3'd0, "R2 no supply stays off", phase, 0);
    supply_ok = 1'b1; lamp_absent = 1'b1;
    repeat (15) @(negedge clk);
    chk(phase == 3'd0 && !hb_en, "R2 lamp absent blocks start", phase, 0);
    lamp_absent = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1, "R2 start pre-heat", phase, 1);
    chk(phase_chg == 1'b1, "R12 strobe on entry", phase_chg, 1);

    // R3 pre-heat length; lamp lights early
    lamp_lit = 1'b1;
    count_phase(1, n);
    chk(n == 12, "R3 pre-heat length", n, 12);
    chk(phase == 3'd2, "R3 ignition follows", phase, 2);
    chk(freq_sel == 12'd200, "R4 first ignition word", freq_sel, 200);
    @(negedge clk);
    chk(freq_sel == 12'd199, "R4 ignition step down", freq_sel, 199);
    chk(phase_chg == 1'b0, "R12 strobe one clock", phase_chg, 0);
    count_phase(2, n);
    chk(n == 6, "R6 ignition length ramp_len+1", n + 1, 7);
    chk(phase == 3'd3, "R6 run reached", phase, 3);
    chk(freq_sel == 12'd100 && eol_en && cs_lo_en, "R6 run word", freq_sel, 100);

    // R10 then R8
    repeat (4) @(negedge clk);
    hb_over_hi = 1'b1;
    @(negedge clk);
    hb_over_hi = 1'b0;
    chk(phase == 3'd4 && !hb_en, "R10 run overcurrent latches", phase, 4);
    lamp_lit = 1'b0;
    repeat (10) @(negedge clk);
    chk(phase == 3'd4, "R8 stop holds without re-lamp", phase, 4);
    lamp_absent = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase == 3'd4, "R8 stop holds while absent", phase, 4);
    lamp_absent = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1, "R8 re-lamp restarts", phase, 1);

    // R7 timeout with a nudge (R5)
    wait_phase(2, "R3 reach ignition");
    n = 1;
    while (phase == 3'd2 && n < 100) begin
      if (n == 3) begin hb_over_hi = 1'b1; f0 = int'(freq_sel); end
      if (n == 4) begin
        hb_over_hi = 1'b0;
        chk(int'(freq_sel) == f0 + 20, "R5 nudge up", int'(freq_sel), f0 + 20);
      end
      @(negedge clk);
      n++;
    end
    chk(n - 1 == 12, "R7 ignition timeout length", n - 1, 12);
    chk(phase == 3'd4 && !hb_en, "R7 timeout stops", phase, 4);

    // relamp, then lamp missing on the last pre-heat cycle (R9 wins)
    lamp_absent = 1'b1; @(negedge clk); lamp_absent = 1'b0; @(negedge clk);
    chk(phase == 3'd1, "R8 re-lamp after timeout", phase, 1);
    repeat (11) @(negedge clk);
    lamp_absent = 1'b1;
    @(negedge clk);
    chk(phase == 3'd4, "R9 absent beats pre-heat expiry", phase, 4);
    lamp_absent = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1, "R8 armed by absent entry", phase, 1);

    // R6: lamp lights on the final timer cycle, run beats timeout
    wait_phase(2, "R3 reach ignition again");
    repeat (11) @(negedge clk);
    chk(phase == 3'd2, "R7 still igniting", phase, 2);
    lamp_lit = 1'b1;
    @(negedge clk);
    chk(phase == 3'd3, "R6 run beats timeout", phase, 3);
    lamp_lit = 1'b0;

    // floor and saturation after reset
    rst = 1'b1;
    cfg_freq_pre = 12'd4090; cfg_freq_run = 12'd4088;
    repeat (2) @(negedge clk);
    chk(phase == 3'd0 && freq_sel == 12'd0, "R1 reset again", phase, 0);
    rst = 1'b0;
    wait_phase(2, "R3 ignition after reset");
    repeat (4) @(negedge clk);
    chk(freq_sel == 12'd4088, "R4 floor at run word", freq_sel, 4088);
    hb_over_hi = 1'b1;
    @(negedge clk);
    chk(freq_sel == 12'd4095, "R5 saturate", freq_sel, 4095);
    @(negedge clk);
    chk(freq_sel == 12'd4095, "R5 stay saturated", freq_sel, 4095);
    hb_over_hi = 1'b0;
    @(negedge clk);
    chk(freq_sel == 12'd4094, "R4 descend after nudge", freq_sel, 4094);
    wait_phase(4, "R7 timeout after reset");
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule